// File: doc/BRIEF.md
# Cycle-Stealing Bus Share Arbiter

This block decides, on every bus-cycle boundary, whether the processor or a DMA engine drives a shared address and data bus. A DMA engine that wants the bus raises a request; the arbiter answers with a grant that always lasts exactly two clock cycles (one transfer slot). While the grant is high, a hold output stalls the processor.

A 2-bit share setting caps how much of the bus the DMA engine may take. It does this by enforcing a minimum run of processor-owned cycles between slots. The resulting DMA shares are 25, 50, 67 or 100 percent. A requester that needs to move two bytes marks its request as a pair. It then gets two slots back to back, which is four cycles, with no processor cycle in between.

After reset the processor owns the bus. The internal count of processor cycles starts saturated, so a first request is served at once.

Top module: `bus_steal_arbiter`

## Requirements
- R1: After reset `dmaGrant`, `cpuHold` and `slotStart` are low. The first request after reset is granted in the cycle after it is sampled, whatever the share setting.
- R2: All outputs are registered and change only at a rising clock edge. When the minimum processor run is already met, a request sampled at one edge shows as `dmaGrant` high from that edge on.
- R3: Every slot holds `dmaGrant` high for exactly two cycles, even if `dmaReq` drops during the slot.
- R4: Between two separate slots the processor owns at least a minimum number of cycles. That minimum is 6 for `bwSel`=00, 2 for 01, 1 for 10 and 0 for 11. Under a steady request the pattern repeats with exactly that gap.
- R5: With `bwSel`=11 and `dmaReq` held high, `dmaGrant` stays high on every cycle and the processor is stalled completely.
- R6: If `dmaPair` is high when a request is accepted, two slots follow back to back (four grant cycles) with no processor cycle between them. This holds even if the request then drops.
- R7: `cpuHold` equals `dmaGrant` on every cycle. `slotStart` is high only on the first cycle of each slot.
- R8: When no request is pending and no slot is running, `dmaGrant` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one cycle is one bus cycle |
| rstN | input | 1 | Active-low synchronous reset |
| dmaReq | input | 1 | DMA engine wants the bus (level) |
| dmaPair | input | 1 | Accepted request needs two consecutive slots |
| bwSel | input | 2 | DMA share setting: 00=25%, 01=50%, 10=67%, 11=100% |
| dmaGrant | output | 1 | DMA owns the buses this cycle |
| cpuHold | output | 1 | Processor is stalled this cycle |
| slotStart | output | 1 | First cycle of a two-cycle slot |

## Verification
A request driven before an edge is sampled at that edge. The grant is visible one cycle later, after the grant register, so the first sample following the request must already show `dmaGrant` high. The bench drives on falling edges and samples on the next falling edge. Sample k therefore reflects the state after edge k, and the expected grant count over a window of W samples is a periodic count over period 2+gap, or 4+gap for pairs. Releases are checked after the longest slot tail (four cycles) has passed, and the idle stretch between vectors is longer than the counter's saturation point, so every vector starts from the same state.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Strobes from the control decision into the datapath registers
  typedef struct packed {
    logic startSlot;  // next cycle begins a new slot
    logic loadPair;   // the new slot is followed by a second one
    logic holdSlot;   // advance from the first to the second slot cycle
    logic freeBus;    // give the bus back to the processor
  } arbStrobe_t;

  typedef enum logic [1:0] {
    SHARE_QUARTER = 2'b00,
    SHARE_HALF    = 2'b01,
    SHARE_TWO3RD  = 2'b10,
    SHARE_FULL    = 2'b11
  } share_e;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int GAP_Q1 = 6,
  parameter int GAP_H  = 2,
  parameter int GAP_T3 = 1,
  parameter int GAP_F  = 0,
  parameter int CNT_W  = 3
) (
  input  logic             dmaReq,
  input  logic             dmaPair,
  input  logic [1:0]       bwSel,
  input  logic             grantQ,
  input  logic             phaseQ,
  input  logic             pairQ,
  input  logic [CNT_W-1:0] cpuCnt,
  output arbStrobe_t       strobe
);

  localparam int CMP_W = CNT_W + 1;

  logic [CMP_W-1:0] minGap;
  logic [CMP_W-1:0] cpuRun;
  logic             gapMet;
  logic             noGap;

  always_comb begin
    case (share_e'(bwSel))
      SHARE_QUARTER: minGap = CMP_W'(GAP_Q1);
      SHARE_HALF:    minGap = CMP_W'(GAP_H);
      SHARE_TWO3RD:  minGap = CMP_W'(GAP_T3);
      default:       minGap = CMP_W'(GAP_F);
    endcase
  end

  // Processor cycles completed, counting the current idle cycle
  assign cpuRun = {1'b0, cpuCnt} + CMP_W'(1);
  assign gapMet = cpuRun >= minGap;
  assign noGap  = (minGap == '0);

  always_comb begin
    strobe = '0;
    if (!grantQ) begin
      if (dmaReq && gapMet) begin
        strobe.startSlot = 1'b1;
        strobe.loadPair  = dmaPair;
      end
    end else if (!phaseQ) begin
      strobe.holdSlot = 1'b1;
    end else if (pairQ) begin
      strobe.startSlot = 1'b1;
      strobe.loadPair  = 1'b0;
    end else if (dmaReq && noGap) begin
      strobe.startSlot = 1'b1;
      strobe.loadPair  = dmaPair;
    end else begin
      strobe.freeBus = 1'b1;
    end
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  arbStrobe_t       strobe,
  output logic             grantQ,
  output logic             phaseQ,
  output logic             pairQ,
  output logic [CNT_W-1:0] cpuCnt
);

  localparam logic [CNT_W-1:0] CNT_SAT = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ <= 1'b0;
      phaseQ <= 1'b0;
      pairQ  <= 1'b0;
      cpuCnt <= CNT_SAT;
    end else begin
      if (strobe.startSlot) begin
        grantQ <= 1'b1;
        phaseQ <= 1'b0;
        pairQ  <= strobe.loadPair;
      end else if (strobe.holdSlot) begin
        phaseQ <= 1'b1;
      end else if (strobe.freeBus) begin
        grantQ <= 1'b0;
        phaseQ <= 1'b0;
        pairQ  <= 1'b0;
      end

      if (strobe.freeBus) begin
        cpuCnt <= '0;
      end else if (!grantQ && cpuCnt != CNT_SAT) begin
        cpuCnt <= cpuCnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/bus_steal_arbiter.sv
module bus_steal_arbiter
  import arb_pkg::*;
#(
  parameter int GAP_Q1 = 6,
  parameter int GAP_H  = 2,
  parameter int GAP_T3 = 1,
  parameter int GAP_F  = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dmaReq,
  input  logic       dmaPair,
  input  logic [1:0] bwSel,
  output logic       dmaGrant,
  output logic       cpuHold,
  output logic       slotStart
);

  localparam int CNT_W = $clog2(GAP_Q1 + 1) < 1 ? 1 : $clog2(GAP_Q1 + 1);

  arbStrobe_t       strobe;
  logic             grantQ;
  logic             phaseQ;
  logic             pairQ;
  logic [CNT_W-1:0] cpuCnt;

  arb_ctrl #(
    .GAP_Q1(GAP_Q1), .GAP_H(GAP_H), .GAP_T3(GAP_T3), .GAP_F(GAP_F),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .dmaReq (dmaReq),
    .dmaPair(dmaPair),
    .bwSel  (bwSel),
    .grantQ (grantQ),
    .phaseQ (phaseQ),
    .pairQ  (pairQ),
    .cpuCnt (cpuCnt),
    .strobe (strobe)
  );

  arb_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .grantQ(grantQ),
    .phaseQ(phaseQ),
    .pairQ (pairQ),
    .cpuCnt(cpuCnt)
  );

  assign dmaGrant  = grantQ;
  assign cpuHold   = grantQ;
  assign slotStart = grantQ && !phaseQ;

endmodule

// File: rtl/bus_steal_arbiter_chk.sv
module bus_steal_arbiter_chk #(
  parameter int GAP_Q1 = 6,
  parameter int GAP_H  = 2,
  parameter int GAP_T3 = 1,
  parameter int GAP_F  = 0
) (
  input logic       clk,
  input logic       rstN,
  input logic       dmaReq,
  input logic       dmaPair,
  input logic [1:0] bwSel,
  input logic       dmaGrant,
  input logic       cpuHold,
  input logic       slotStart
);

  logic [3:0] idleRun;
  logic [1:0] prevSel;
  logic [3:0] needGap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleRun <= 4'd15;
      prevSel <= 2'b00;
    end else begin
      prevSel <= bwSel;
      if (dmaGrant) idleRun <= '0;
      else if (idleRun != 4'd15) idleRun <= idleRun + 4'd1;
    end
  end

  always_comb begin
    case (prevSel)
      2'b00:   needGap = 4'(GAP_Q1);
      2'b01:   needGap = 4'(GAP_H);
      2'b10:   needGap = 4'(GAP_T3);
      default: needGap = 4'(GAP_F);
    endcase
  end

  // R7
  always_comb begin
    if (rstN) hold_match_chk: assert (cpuHold == dmaGrant);
  end

  // R3
  slot_two_cycles_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |=> (dmaGrant && !slotStart));

  // R7
  start_only_in_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    slotStart |-> dmaGrant);

  // R4
  min_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dmaGrant) |-> (idleRun >= needGap));

  // R8
  no_req_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaReq && !dmaGrant) |=> !dmaGrant);

endmodule

bind bus_steal_arbiter bus_steal_arbiter_chk #(
  .GAP_Q1(GAP_Q1), .GAP_H(GAP_H), .GAP_T3(GAP_T3), .GAP_F(GAP_F)
) i_chk (
  .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .dmaPair(dmaPair), .bwSel(bwSel),
  .dmaGrant(dmaGrant), .cpuHold(cpuHold), .slotStart(slotStart)
);

// File: tb/test_bus_steal_arbiter.sv
module test_bus_steal_arbiter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dmaReq = 1'b0;
  logic       dmaPair = 1'b0;
  logic [1:0] bwSel = 2'b00;
  logic       dmaGrant, cpuHold, slotStart;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bus_steal_arbiter i_bus_steal_arbiter (
    .clk(clk), .rstN(rstN), .dmaReq(dmaReq), .dmaPair(dmaPair),
    .bwSel(bwSel), .dmaGrant(dmaGrant), .cpuHold(cpuHold),
    .slotStart(slotStart)
  );

  localparam int WIN = 16;
  localparam int NVEC = 8;
  // {bwSel, pair, expected grant cycles within WIN samples}
  typedef struct packed { logic [1:0] sel; logic pair; logic [7:0] grants; } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 1'b0, 8'd4},  '{2'b01, 1'b0, 8'd8},
    '{2'b10, 1'b0, 8'd11}, '{2'b11, 1'b0, 8'd16},
    '{2'b00, 1'b1, 8'd8},  '{2'b01, 1'b1, 8'd12},
    '{2'b10, 1'b1, 8'd13}, '{2'b11, 1'b1, 8'd16}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int grants, holdBad, starts;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!dmaGrant && !cpuHold && !slotStart, "R1", dmaGrant, 0);
    // R8 idle with no request
    grants = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); grants += int'(dmaGrant); end
    check(grants == 0, "R8", grants, 0);

    // Table walk: R2 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      bwSel = VECS[v].sel;
      dmaPair = VECS[v].pair;
      dmaReq = 1'b1;
      grants = 0; holdBad = 0; starts = 0;
      for (int k = 1; k <= WIN; k++) begin
        @(negedge clk);
        if (k == 1) check(dmaGrant == 1'b1, "R2", dmaGrant, 1);
        grants += int'(dmaGrant);
        starts += int'(slotStart);
        if (cpuHold != dmaGrant) holdBad++;
      end
      dmaReq = 1'b0;
      if (VECS[v].sel == 2'b11) check(grants == WIN, "R5", grants, WIN);
      else if (VECS[v].pair) check(grants == int'(VECS[v].grants), "R6", grants, int'(VECS[v].grants));
      else check(grants == int'(VECS[v].grants), "R4", grants, int'(VECS[v].grants));
      check(holdBad == 0, "R7", holdBad, 0);
      // R7: each slot is two cycles, so starts is at least grants/2
      check(starts * 2 >= grants && starts > 0, "R7", starts, (grants + 1) / 2);
      repeat (5) @(negedge clk);
      grants = 0;
      for (int k = 0; k < 10; k++) begin @(negedge clk); grants += int'(dmaGrant); end
      check(grants == 0, "R8", grants, 0);
    end

    // R3: one-cycle request pulse still yields a full two-cycle slot
    bwSel = 2'b00; dmaPair = 1'b0; dmaReq = 1'b1;
    grants = 0;
    @(negedge clk);
    dmaReq = 1'b0;
    check(slotStart == 1'b1, "R3", slotStart, 1);
    grants += int'(dmaGrant);
    @(negedge clk);
    check(slotStart == 1'b0 && dmaGrant, "R3", slotStart, 0);
    grants += int'(dmaGrant);
    for (int k = 0; k < 8; k++) begin @(negedge clk); grants += int'(dmaGrant); end
    check(grants == 2, "R3", grants, 2);

    // R6: one-cycle pair pulse yields four consecutive grant cycles
    repeat (8) @(negedge clk);
    dmaPair = 1'b1; dmaReq = 1'b1;
    grants = 0;
    @(negedge clk);
    dmaReq = 1'b0; dmaPair = 1'b0;
    grants += int'(dmaGrant);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(dmaGrant == 1'b1, "R6", dmaGrant, 1);
      grants += int'(dmaGrant);
    end
    for (int k = 0; k < 6; k++) begin @(negedge clk); grants += int'(dmaGrant); end
    check(grants == 4, "R6", grants, 4);

    // R4: at 50% a new request right after a slot waits two processor cycles
    repeat (8) @(negedge clk);
    bwSel = 2'b01; dmaReq = 1'b1;
    repeat (2) @(negedge clk);
    check(dmaGrant == 1'b1, "R4", dmaGrant, 1);
    @(negedge clk);
    check(dmaGrant == 1'b0, "R4", dmaGrant, 0);
    @(negedge clk);
    check(dmaGrant == 1'b0, "R4", dmaGrant, 0);
    @(negedge clk);
    check(slotStart == 1'b1, "R4", slotStart, 1);
    dmaReq = 1'b0;

    // R1: reset with request pending, then grant right after release
    @(negedge clk);
    rstN = 1'b0; bwSel = 2'b00; dmaReq = 1'b1;
    @(negedge clk);
    check(!dmaGrant, "R1", dmaGrant, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(dmaGrant == 1'b1, "R1", dmaGrant, 1);
    dmaReq = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end

endmodule